// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block holds received characters between a serial deserializer and the register interface of a 16550-style UART. It works in one of two modes chosen by a control write. In the first, each arriving byte replaces a single holding register. In the second, bytes queue in a 16-entry first-in first-out store. That store has a selectable trigger threshold and refuses new bytes when it is full. A line break arrives on its own strobe and is stored as a zero byte, together with a sticky break indication.

In queued mode a character timer watches for inactivity. The length of one character is the bit period, taken from an external baud tick, multiplied by the frame length. The frame length comes from the word-length, parity and stop-bit settings of the line control. Four character times without a received byte or a read that leaves data behind raise a timeout-pending flag, provided data is still waiting. A control write can flush the store. Reading the line status clears the sticky error indications.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the block is in holding-register mode, `ctl_q` is 0, `fill` is 0, `rd_byte` is 0x00, and `data_ready`, `overrun`, `brk_flag`, `trig_hit` and `tmo_pend` are all 0.
- R2: In queued mode (`ctl_q[0]`=1), `rd_byte` shows the oldest stored byte and `fill` counts stored bytes. A `data_rd` removes the oldest byte, so bytes leave in arrival order. `data_ready` is 1 exactly when `fill` is nonzero. `rd_byte` is 0x00 when the store is empty, and a read of an empty store changes nothing in it.
- R3: `ctl_q[7:6]` selects the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. In queued mode `trig_hit` is 1 when `fill` is at least the threshold. In holding-register mode `trig_hit` equals `data_ready`.
- R4: In queued mode, a byte that arrives when the store is full and no read occurs in that cycle is dropped. The stored contents are kept and `overrun` is set. If a read occurs in the same cycle, the byte is accepted and `overrun` is not set.
- R5: In holding-register mode every arriving byte replaces the holding register and sets `data_ready`. `overrun` is set if `data_ready` was already 1 and no read occurs in that cycle. A read with no arriving byte clears `data_ready`. `rd_byte` shows the holding register.
- R6: `brk_stb` enters the byte 0x00 exactly like a received byte, with the same overrun rules, and sets `brk_flag`. When `brk_stb` and `rx_stb` are both high, only the zero byte is entered.
- R7: `brk_flag` is cleared by a status read (`stat_rd`) or by a data read that leaves no data, which in holding-register mode is any data read. `overrun` is cleared by a status read. A setting event in the same cycle wins over the clear.
- R8: A control write loads `ctl_q` with `ctl_wdata & 0xC9`. If `ctl_wdata[1]` is 1, or `ctl_wdata[0]` differs from `ctl_q[0]`, a receive reset happens. The reset empties the store, clears the holding register to 0x00 and its valid state, and clears `brk_flag`, the timer and `tmo_pend`. `overrun` is kept.
- R9: In a cycle with a control write, `rx_stb`, `brk_stb` and `data_rd` are ignored.
- R10: The frame length in bits is 1 + (5 + `frame_cfg[1:0]`) + `frame_cfg[3]` + (1 + `frame_cfg[2]`). In queued mode the timer restarts on every arriving byte or break and on every read that leaves data. It counts `baud_tick` cycles and never counts in a restart cycle. On the tick that completes 4 × frame-length ticks it stops, and `tmo_pend` is 1 from the next cycle if `fill` is nonzero.
- R11: Any data read in queued mode clears `tmo_pend`. A read that empties the store stops the timer. In holding-register mode `tmo_pend` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| brk_stb | input | 1 | A line break was detected this cycle |
| data_rd | input | 1 | Data register read strobe |
| stat_rd | input | 1 | Line status read strobe |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write value (bit 0 mode, bit 1 receive reset, bits 7:6 threshold) |
| frame_cfg | input | 4 | Frame format: [1:0] word length minus 5, [2] two stop bits, [3] parity present |
| baud_tick | input | 1 | One pulse per bit period |
| rd_byte | output | 8 | Byte a data read returns |
| ctl_q | output | 8 | Retained control value |
| data_ready | output | 1 | Data available |
| overrun | output | 1 | Sticky overrun indication |
| brk_flag | output | 1 | Sticky break indication |
| fill | output | 5 | Number of stored bytes |
| trig_hit | output | 1 | Fill at or above trigger threshold |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
The hardest collision is an arriving byte and a data read in the same cycle. The outcome depends on the state: with the store full the byte must be accepted with no overrun, and in holding-register mode `data_ready` must stay set with no overrun. A break strobe that meets a status read, and a timer expiry that meets a read, are the same kind of collision. Directed sequences force each of these cycles on purpose. A long stretch of pseudo-random strobes then makes them happen at every fill level. Each cycle the outputs are compared with a queue-based reference model that applies the requirement rules in their stated priority.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_stb,
  input  logic [7:0]    rx_byte,
  input  logic          brk_stb,
  input  logic          data_rd,
  input  logic          stat_rd,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic [3:0]    frame_cfg,
  input  logic          baud_tick,
  output logic [7:0]    rd_byte,
  output logic [7:0]    ctl_q,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_flag,
  output logic [CW-1:0] fill,
  output logic          trig_hit,
  output logic          tmo_pend
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [7:0]    hold;
  logic          hold_v;
  logic [5:0]    tmr;
  logic          tmr_run;

  wire fifo_on = ctl_q[0];
  wire flip    = ctl_wr && (ctl_wdata[0] ^ ctl_q[0]);
  wire rx_clr  = ctl_wr && (ctl_wdata[1] || flip);
  wire in_stb  = !ctl_wr && (rx_stb || brk_stb);
  wire [7:0] in_byte = brk_stb ? 8'h00 : rx_byte;
  wire rd_go   = !ctl_wr && data_rd;
  wire empty   = (fill == '0);
  wire full    = (fill == CW'(DEPTH));
  wire pop     = rd_go && fifo_on && !empty;
  wire push    = in_stb && fifo_on && (!full || pop);
  wire ovr_set = in_stb && (fifo_on ? (full && !pop) : (hold_v && !rd_go));
  wire [CW-1:0] fill_nxt = fill + CW'(push) - CW'(pop);

  logic [CW-1:0] level;
  always_comb begin
    case (ctl_q[7:6])
      2'b00:   level = CW'(1);
      2'b01:   level = CW'(4);
      2'b10:   level = CW'(8);
      default: level = CW'(14);
    endcase
  end

  wire [3:0] frame_len = 4'd7 + {2'b00, frame_cfg[1:0]} + {3'b000, frame_cfg[3]} + {3'b000, frame_cfg[2]};
  wire [5:0] limit     = {frame_len, 2'b00};
  wire restart  = fifo_on && (in_stb || (pop && fill_nxt != '0));
  wire stop_emp = pop && (fill_nxt == '0);
  wire expire   = tmr_run && baud_tick && (tmr + 6'd1 >= limit);

  assign data_ready = fifo_on ? !empty : hold_v;
  assign rd_byte    = fifo_on ? (empty ? 8'h00 : mem[rptr]) : hold;
  assign trig_hit   = fifo_on ? (fill >= level) : hold_v;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      hold <= '0;
      hold_v <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_wdata & 8'hC9;
      if (rx_clr) begin
        wptr <= '0;
        rptr <= '0;
        fill <= '0;
        hold <= '0;
        hold_v <= 1'b0;
      end else begin
        if (push) wptr <= wptr + 1'b1;
        if (pop) rptr <= rptr + 1'b1;
        fill <= fill_nxt;
        if (!fifo_on) begin
          if (in_stb) begin
            hold <= in_byte;
            hold_v <= 1'b1;
          end else if (rd_go) begin
            hold_v <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      if (ovr_set) overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
      if (rx_clr) brk_flag <= 1'b0;
      else if (brk_stb && !ctl_wr) brk_flag <= 1'b1;
      else if (stat_rd || (rd_go && (!fifo_on || fill_nxt == '0))) brk_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      tmr_run <= 1'b0;
      tmo_pend <= 1'b0;
    end else if (rx_clr) begin
      tmr <= '0;
      tmr_run <= 1'b0;
      tmo_pend <= 1'b0;
    end else begin
      if (restart) begin
        tmr <= '0;
        tmr_run <= 1'b1;
      end else if (stop_emp) begin
        tmr_run <= 1'b0;
      end else if (tmr_run && baud_tick) begin
        tmr <= tmr + 6'd1;
        if (expire) tmr_run <= 1'b0;
      end
      if (rd_go && fifo_on) tmo_pend <= 1'b0;
      else if (expire && !restart && !stop_emp && !empty) tmo_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_stb,
  input logic          brk_stb,
  input logic          data_rd,
  input logic          stat_rd,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_q,
  input logic [7:0]    rd_byte,
  input logic          data_ready,
  input logic          overrun,
  input logic          brk_flag,
  input logic [CW-1:0] fill,
  input logic          trig_hit,
  input logic          tmo_pend
);

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  a_r2_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !data_ready) |-> (rd_byte == 8'h00));

  a_r3_trig_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready);

  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && fill == CW'(DEPTH) && rx_stb && !data_rd && !ctl_wr)
    |=> (overrun && fill == CW'(DEPTH)));

  a_r6_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stb && !ctl_wr) |=> (brk_flag && data_ready));

  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_stb && !brk_stb) |=> (!overrun && !brk_flag));

  a_r8_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q == ($past(ctl_wdata) & 8'hC9)));

  a_r9_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_q[0] && ctl_wdata[0] && !ctl_wdata[1]) |=> (fill == $past(fill)));

  a_r11_no_tmo_holding: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> !tmo_pend);

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_uart_rx_buffer.sv
`timescale 1ns/1ps
module test_uart_rx_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_stb = 0, brk_stb = 0, data_rd = 0, stat_rd = 0, ctl_wr = 0, baud_tick = 0;
  logic [7:0] rx_byte = 0, ctl_wdata = 0;
  logic [3:0] frame_cfg = 4'b0011;
  logic [7:0] rd_byte, ctl_q;
  logic data_ready, overrun, brk_flag, trig_hit, tmo_pend;
  logic [4:0] fill;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_q[$];
  logic [7:0] m_fcr = 0, m_hold = 0;
  bit m_hv = 0, m_ovr = 0, m_brk = 0, m_tmo = 0, m_trun = 0;
  int m_tcnt = 0;

  uart_rx_buffer i_uart_rx_buffer (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit fon = m_fcr[0];
    int lvl;
    case (m_fcr[7:6]) 2'd0: lvl = 1; 2'd1: lvl = 4; 2'd2: lvl = 8; default: lvl = 14; endcase
    chk("R1/R8 ctl_q", ctl_q, m_fcr);
    chk("R2/R5 rd_byte", rd_byte, fon ? (m_q.size() > 0 ? m_q[0] : 0) : m_hold);
    chk("R2/R5 data_ready", data_ready, fon ? (m_q.size() > 0) : m_hv);
    chk("R2/R4 fill", fill, m_q.size());
    chk("R3 trig_hit", trig_hit, fon ? (m_q.size() >= lvl) : m_hv);
    chk("R4/R5/R7 overrun", overrun, m_ovr);
    chk("R6/R7 brk_flag", brk_flag, m_brk);
    chk("R10/R11 tmo_pend", tmo_pend, m_tmo);
  endtask

  task automatic model_step();
    bit fon = m_fcr[0];
    bit flip = ctl_wr && (ctl_wdata[0] != m_fcr[0]);
    bit clr = ctl_wr && (ctl_wdata[1] || flip);
    bit ins = !ctl_wr && (rx_stb || brk_stb);
    bit rdg = !ctl_wr && data_rd;
    logic [7:0] ib = brk_stb ? 8'h00 : rx_byte;
    bit popd = 0, ovs = 0;
    int lim = 4 * (1 + 5 + frame_cfg[1:0] + frame_cfg[3] + 1 + frame_cfg[2]);
    if (clr) begin
      m_q.delete(); m_hold = 0; m_hv = 0; m_brk = 0; m_tmo = 0; m_trun = 0; m_tcnt = 0;
    end else begin
      if (fon) begin
        int n0 = m_q.size();
        popd = rdg && n0 > 0;
        if (popd) void'(m_q.pop_front());
        if (ins) begin
          if (n0 < 16 || popd) m_q.push_back(ib);
          else ovs = 1;
        end
      end else begin
        if (ins) begin
          ovs = m_hv && !rdg;
          m_hold = ib; m_hv = 1;
        end else if (rdg) m_hv = 0;
      end
      if (brk_stb && !ctl_wr) m_brk = 1;
      else if (stat_rd || (rdg && (!fon || m_q.size() == 0))) m_brk = 0;
      if (fon && rdg) m_tmo = 0;
      if (fon && (ins || (popd && m_q.size() > 0))) begin
        m_trun = 1; m_tcnt = 0;
      end else if (popd) begin
        m_trun = 0;
      end else if (m_trun && baud_tick) begin
        m_tcnt++;
        if (m_tcnt >= lim) begin
          m_trun = 0;
          if (m_q.size() > 0) m_tmo = 1;
        end
      end
    end
    if (ovs) m_ovr = 1;
    else if (stat_rd) m_ovr = 0;
    if (ctl_wr) m_fcr = ctl_wdata & 8'hC9;
  endtask

  task automatic cy(input bit rs = 0, input logic [7:0] rb = 0, input bit bs = 0,
                    input bit rd = 0, input bit sr = 0, input bit wr = 0,
                    input logic [7:0] wd = 0, input bit tk = 0);
    compare();
    rx_stb = rs; rx_byte = rb; brk_stb = bs; data_rd = rd; stat_rd = sr;
    ctl_wr = wr; ctl_wdata = wd; baud_tick = tk;
    model_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R5 holding mode
    cy();
    cy(.rs(1), .rb(8'h11));
    cy(.rs(1), .rb(8'h22));
    cy(.sr(1));
    cy(.rd(1), .rs(1), .rb(8'h33));
    cy(.rd(1));
    cy();
    // R8 mask, mode toggle, R3 threshold 4
    cy(.wr(1), .wd(8'hFF));
    cy(.wr(1), .wd(8'h43));
    for (int i = 0; i < 17; i++) cy(.rs(1), .rb(8'(8'hA0 + i)));  // R4 overflow
    cy(.rs(1), .rb(8'h5A), .rd(1));                                 // R4 read frees slot
    cy(.sr(1));
    for (int i = 0; i < 18; i++) cy(.rd(1));                         // R2 order and empty read
    // R3 other thresholds
    for (int k = 0; k < 4; k++) begin
      cy(.wr(1), .wd(8'((k << 6) | 3)));
      for (int i = 0; i < 15; i++) cy(.rs(1), .rb(8'(i)));
    end
    // R6 break with rx, R7 status read meets break
    cy(.wr(1), .wd(8'h03));
    cy(.bs(1), .rs(1), .rb(8'h77));
    cy(.bs(1), .sr(1));
    cy(.rd(1));
    cy(.rd(1));
    // R9 write blocks receive and read
    cy(.rs(1), .rb(8'h10));
    cy(.wr(1), .wd(8'h01), .rs(1), .rb(8'h99), .rd(1));
    // R10 timeout, then R11 read clears
    for (int f = 0; f < 16; f += 5) begin
      frame_cfg = 4'(f);
      cy(.rs(1), .rb(8'h42));
      for (int i = 0; i < 60; i++) cy(.tk(1));
      cy(.rd(1));
      cy(.rd(1));
    end
    // mixed pseudo-random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] wd = 8'($urandom);
      if (($urandom % 5) != 0) wd[0] = 1'b1;
      if (($urandom % 300) == 0) frame_cfg = 4'($urandom);
      cy(.rs(($urandom % 10) < 4), .rb(8'($urandom)), .bs(($urandom % 40) == 0),
         .rd(($urandom % 10) < 3), .sr(($urandom % 10) == 0),
         .wr(($urandom % 80) == 0), .wd(wd), .tk(($urandom % 2) == 0));
    end
    cy();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule